// File: doc/BRIEF.md
# Field-addressed indirect register accessor

This engine reaches a register file that exposes only two bus locations: a pointer port that selects a register and channel, and a data port that reads or writes the selected word. A requester hands the engine one command (a register number, a channel number, write data and a read/write flag). The engine composes the pointer word, writes it, and then performs a data read, a whole-word data write, or a field read-merge-write. The bus is locked from the pointer beat through the last data beat, so no other master can slip a pointer write into the sequence.

The upper byte of the register number is a field descriptor. When it is nonzero, the command touches only a bit range: a 6-bit size and a 5-bit offset pick the bits. A field read returns those bits right-aligned. A field write replaces only those bits and keeps the rest of the word. Commands with illegal arguments are refused before any bus traffic.

The command side is valid/ready. `cmd_ready` is high only while the engine is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. The requester must hold every `cmd_*` field stable while `cmd_valid` is high and `cmd_ready` is low. The bus side is single-beat valid/ready: a beat completes when `bus_valid` and `bus_ready` are both high, and read data is taken in that same cycle. The engine holds its request unchanged while `bus_ready` is low. Results come back as a one-cycle `done` pulse with `rsp_err` and `rsp_rdata`.

Top module: `field_reg_accessor`

## Requirements
- R1: The first bus beat of an accepted, legal command is a pointer write (`bus_sel`=0, `bus_write`=1) carrying `{cmd_reg[15:0], cmd_chan[15:0]}`.
- R2: `cmd_ready` is high only in the idle state. Each accepted command produces exactly one `done` pulse, one cycle long. `cmd_ready` is low during that pulse and high again in the cycle after it.
- R3: A plain read (`cmd_reg[31:24]`=0, `cmd_write`=0) makes two beats, a pointer write and then a data read (`bus_sel`=1, `bus_write`=0), and returns the whole data word with `rsp_err`=0.
- R4: A plain write makes two beats, a pointer write and then a data write of `cmd_wdata`, and reports `rsp_err`=0 and `rsp_rdata`=0.
- R5: A nonzero `cmd_reg[31:24]` selects a field with size `cmd_reg[29:24]` and offset `cmd_reg[20:16]`. A field read returns `(word >> offset) & ((1<<size)-1)`.
- R6: A field write makes three beats: a pointer write, a data read and a data write. The written word is the read word with the field bits replaced by `cmd_wdata` shifted to the offset, and every bit outside the field is unchanged.
- R7: A field write whose `cmd_wdata` has any bit set at or above the field size is rejected.
- R8: A command is rejected when `cmd_chan` has a bit outside `CHAN_MASK` or when `cmd_reg[15:0]` has a bit outside `ADDR_MASK`.
- R9: A command is rejected when size plus offset exceeds 32, when a field command has `cmd_reg[31:30]` or `cmd_reg[23:21]` set, or when a plain command has any of `cmd_reg[23:16]` set.
- R10: A rejected command makes no bus beat and raises `done` in the cycle after acceptance, with `rsp_err`=1 and `rsp_rdata`=0.
- R11: A descriptor of size 32 with offset 0 is a whole-word access: a write makes only a pointer beat and a data write beat, and a read returns the full word.
- R12: `bus_lock` is high on every beat of a sequence and stays high from the pointer beat through the last data beat. While `bus_ready` is low, the pending request holds its select, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_reg | input | 32 | Register number; upper byte is the field descriptor |
| cmd_chan | input | 16 | Channel number |
| cmd_wdata | input | 32 | Write data, right-aligned for field writes |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command was rejected (valid with done) |
| rsp_rdata | output | 32 | Read result (valid with done) |
| bus_valid | output | 1 | Bus beat requested |
| bus_ready | input | 1 | Bus beat accepted |
| bus_sel | output | 1 | 0 = pointer port, 1 = data port |
| bus_write | output | 1 | 1 = write beat, 0 = read beat |
| bus_wdata | output | 32 | Pointer word or data word |
| bus_rdata | input | 32 | Data port read value |
| bus_lock | output | 1 | Bus held for an indivisible sequence |

## Verification
The completion pulse of one command and the arrival of the next command can fall in the same cycle. A requester that keeps `cmd_valid` high across a running sequence lands its second command on the `done` cycle. The bench provokes this by presenting a read of a word right after a write to the same word has been accepted. It judges the case by three things: `cmd_ready` is low while `done` is high, the second command is taken only in the following cycle, and the read returns the freshly written value. A second overlap is a stall on the bus during a read-merge-write, where the read beat and the back-pressure meet. The bench checks that the merged result is still correct and that the lock never drops between beats.

// File: rtl/iracc_pkg.sv
package iracc_pkg;

  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int SIZE_W   = 6;
  localparam int OFF_W    = $clog2(WORD_W);
  localparam int SIZE_LSB = 24;
  localparam int OFF_LSB  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_t;

  // Ones in the low s bits; s of WORD_W or more gives all ones.
  function automatic logic [WORD_W-1:0] field_mask(input logic [SIZE_W-1:0] s);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = (32'(i) < {26'b0, s});
    end
    return m;
  endfunction

endpackage

// File: rtl/iracc_decode.sv
module iracc_decode
  import iracc_pkg::*;
#(
  parameter logic [HALF_W-1:0] CHAN_MASK = 16'h003F,
  parameter logic [HALF_W-1:0] ADDR_MASK = 16'h07FF
) (
  input  logic              cmd_write,
  input  logic [WORD_W-1:0] cmd_reg,
  input  logic [HALF_W-1:0] cmd_chan,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] ptr_word,
  output logic              is_field,
  output logic [SIZE_W-1:0] fsize,
  output logic [OFF_W-1:0]  foff,
  output logic              reject
);

  logic desc_present;
  logic whole_word;
  logic chan_bad, addr_bad, resv_bad, range_bad, data_bad;
  logic [SIZE_W:0] span;

  assign fsize        = cmd_reg[SIZE_LSB +: SIZE_W];
  assign foff         = cmd_reg[OFF_LSB +: OFF_W];
  assign desc_present = (cmd_reg[WORD_W-1:SIZE_LSB] != '0);
  assign whole_word   = (fsize == SIZE_W'(WORD_W)) && (foff == '0);
  assign is_field     = desc_present && !whole_word;

  assign ptr_word = {cmd_reg[HALF_W-1:0], cmd_chan};

  assign span = {1'b0, fsize} + {{(SIZE_W+1-OFF_W){1'b0}}, foff};

  assign chan_bad  = (cmd_chan & ~CHAN_MASK) != '0;
  assign addr_bad  = (cmd_reg[HALF_W-1:0] & ~ADDR_MASK) != '0;
  assign resv_bad  = desc_present
                   ? ((cmd_reg[WORD_W-1:SIZE_LSB+SIZE_W] != '0) ||
                      (cmd_reg[SIZE_LSB-1:OFF_LSB+OFF_W] != '0))
                   : (cmd_reg[SIZE_LSB-1:OFF_LSB] != '0);
  assign range_bad = desc_present && (span > (SIZE_W+1)'(WORD_W));
  assign data_bad  = is_field && cmd_write && ((cmd_wdata & ~field_mask(fsize)) != '0);

  assign reject = chan_bad || addr_bad || resv_bad || range_bad || data_bad;

endmodule

// File: rtl/iracc_field.sv
module iracc_field
  import iracc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [SIZE_W-1:0] fsize,
  input  logic [OFF_W-1:0]  foff,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] extract,
  output logic [WORD_W-1:0] merged
);

  logic [WORD_W-1:0] msk;

  for (genvar g = 0; g < WORD_W; g++) begin : g_mask
    assign msk[g] = (SIZE_W'(g) < fsize);
  end

  assign extract = (word >> foff) & msk;
  assign merged  = (word & ~(msk << foff)) | ((wdata & msk) << foff);

endmodule

// File: rtl/iracc_seq.sv
module iracc_seq
  import iracc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [WORD_W-1:0] dec_ptr,
  input  logic              dec_field,
  input  logic [SIZE_W-1:0] dec_size,
  input  logic [OFF_W-1:0]  dec_off,
  input  logic              dec_reject,
  output logic [SIZE_W-1:0] cap_size,
  output logic [OFF_W-1:0]  cap_off,
  output logic [WORD_W-1:0] cap_wdata,
  input  logic [WORD_W-1:0] fld_extract,
  input  logic [WORD_W-1:0] fld_merged,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_sel,
  output logic              bus_write,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              bus_lock,
  output logic              done,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata
);

  seq_state_t        state;
  logic              cap_write;
  logic              cap_field;
  logic [WORD_W-1:0] cap_ptr;
  logic [WORD_W-1:0] wr_word;
  logic              lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_write <= 1'b0;
      cap_field <= 1'b0;
      cap_size  <= '0;
      cap_off   <= '0;
      cap_ptr   <= '0;
      cap_wdata <= '0;
      wr_word   <= '0;
      lock_q    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          cap_write <= cmd_write;
          cap_field <= dec_field;
          cap_size  <= dec_size;
          cap_off   <= dec_off;
          cap_ptr   <= dec_ptr;
          cap_wdata <= cmd_wdata;
          wr_word   <= cmd_wdata;
          rsp_rdata <= '0;
          rsp_err   <= dec_reject;
          lock_q    <= !dec_reject;
          state     <= dec_reject ? ST_DONE : ST_PTR;
        end
        ST_PTR: if (bus_ready) begin
          state <= (cap_write && !cap_field) ? ST_WR : ST_RD;
        end
        ST_RD: if (bus_ready) begin
          if (cap_write) begin
            wr_word <= fld_merged;
            state   <= ST_WR;
          end else begin
            rsp_rdata <= cap_field ? fld_extract : bus_rdata;
            lock_q    <= 1'b0;
            state     <= ST_DONE;
          end
        end
        ST_WR: if (bus_ready) begin
          lock_q <= 1'b0;
          state  <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign bus_valid = (state == ST_PTR) || (state == ST_RD) || (state == ST_WR);
  assign bus_sel   = (state != ST_PTR);
  assign bus_write = (state == ST_PTR) || (state == ST_WR);
  assign bus_wdata = (state == ST_PTR) ? cap_ptr : wr_word;
  assign bus_lock  = lock_q;

endmodule

// File: rtl/field_reg_accessor.sv
module field_reg_accessor
  import iracc_pkg::*;
#(
  parameter logic [HALF_W-1:0] CHAN_MASK = 16'h003F,
  parameter logic [HALF_W-1:0] ADDR_MASK = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [WORD_W-1:0] cmd_reg,
  input  logic [HALF_W-1:0] cmd_chan,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              done,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_sel,
  output logic              bus_write,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              bus_lock
);

  logic [WORD_W-1:0] dec_ptr;
  logic              dec_field;
  logic [SIZE_W-1:0] dec_size;
  logic [OFF_W-1:0]  dec_off;
  logic              dec_reject;
  logic [SIZE_W-1:0] cap_size;
  logic [OFF_W-1:0]  cap_off;
  logic [WORD_W-1:0] cap_wdata;
  logic [WORD_W-1:0] fld_extract;
  logic [WORD_W-1:0] fld_merged;

  iracc_decode #(
    .CHAN_MASK(CHAN_MASK),
    .ADDR_MASK(ADDR_MASK)
  ) u_decode (
    .cmd_write(cmd_write),
    .cmd_reg  (cmd_reg),
    .cmd_chan (cmd_chan),
    .cmd_wdata(cmd_wdata),
    .ptr_word (dec_ptr),
    .is_field (dec_field),
    .fsize    (dec_size),
    .foff     (dec_off),
    .reject   (dec_reject)
  );

  iracc_field u_field (
    .word   (bus_rdata),
    .fsize  (cap_size),
    .foff   (cap_off),
    .wdata  (cap_wdata),
    .extract(fld_extract),
    .merged (fld_merged)
  );

  iracc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .cmd_wdata  (cmd_wdata),
    .dec_ptr    (dec_ptr),
    .dec_field  (dec_field),
    .dec_size   (dec_size),
    .dec_off    (dec_off),
    .dec_reject (dec_reject),
    .cap_size   (cap_size),
    .cap_off    (cap_off),
    .cap_wdata  (cap_wdata),
    .fld_extract(fld_extract),
    .fld_merged (fld_merged),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_sel    (bus_sel),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_lock   (bus_lock),
    .done       (done),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/iracc_checker.sv
module iracc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_reg,
  input logic [15:0] cmd_chan,
  input logic        done,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_sel,
  input logic        bus_write,
  input logic [31:0] bus_wdata,
  input logic        bus_lock
);

  assert_first_beat_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (done || (bus_valid && !bus_sel && bus_write &&
      bus_wdata == {$past(cmd_reg[15:0]), $past(cmd_chan)})));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_ready_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);

  assert_reject_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_err) |-> (rsp_rdata == 32'h0 && !bus_valid));

  assert_lock_on_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_lock);

  assert_lock_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> done);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_sel) &&
      $stable(bus_write) && $stable(bus_wdata)));

endmodule

bind field_reg_accessor iracc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_reg  (cmd_reg),
  .cmd_chan (cmd_chan),
  .done     (done),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_sel  (bus_sel),
  .bus_write(bus_write),
  .bus_wdata(bus_wdata),
  .bus_lock (bus_lock)
);

// File: tb/field_reg_accessor_test.sv
module field_reg_accessor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_reg = '0;
  logic [15:0] cmd_chan = '0;
  logic [31:0] cmd_wdata = '0;
  logic        done;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_valid;
  logic        bus_ready;
  logic        bus_sel;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_lock;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  field_reg_accessor uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_reg(cmd_reg), .cmd_chan(cmd_chan), .cmd_wdata(cmd_wdata),
    .done(done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_sel(bus_sel),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_lock(bus_lock)
  );

  // Register file model behind the pointer/data pair.
  logic [31:0] mem [32];
  logic [31:0] ptr_q;
  logic [1:0]  stall_cnt;
  logic        stall_mode = 1'b0;
  logic [1:0]  beat_kind [16];
  int          total_beats;
  int          lock_bad;

  function automatic logic [31:0] init_word(input int i);
    return 32'h9E3779B9 * 32'(i + 1);
  endfunction

  function automatic logic [4:0] idx_of(input logic [31:0] p);
    return {p[17:16], p[2:0]};
  endfunction

  assign bus_rdata = mem[idx_of(ptr_q)];
  assign bus_ready = !stall_mode || (stall_cnt == 2'd3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= init_word(i);
      ptr_q       <= '0;
      stall_cnt   <= '0;
      total_beats <= 0;
      lock_bad    <= 0;
    end else begin
      stall_cnt <= stall_cnt + 2'd1;
      if (bus_valid && bus_ready) begin
        if (!bus_sel) ptr_q <= bus_wdata;
        else if (bus_write) mem[idx_of(ptr_q)] <= bus_wdata;
        beat_kind[total_beats % 16] <= {bus_sel, bus_write};
        total_beats <= total_beats + 1;
        if (!bus_lock) lock_bad <= lock_bad + 1;
      end
    end
  end

  localparam logic [1:0] K_PTR = 2'b01, K_RD = 2'b10, K_WR = 2'b11;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Issue one command and wait for its completion.
  task automatic run_cmd(input bit w, input logic [31:0] r, input logic [15:0] c,
                         input logic [31:0] d, output bit err, output logic [31:0] rd,
                         output int beats, output logic [5:0] kinds);
    int base;
    int t;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_reg = r; cmd_chan = c; cmd_wdata = d;
    base = total_beats;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 60) begin @(negedge clk); t++; end
    check(done, "R2 completion", 32'(done), 32'h1);
    err   = rsp_err;
    rd    = rsp_rdata;
    beats = total_beats - base;
    kinds = {beat_kind[(base) % 16], beat_kind[(base + 1) % 16], beat_kind[(base + 2) % 16]};
  endtask

  task automatic t_reset();
    check(cmd_ready && !done && !bus_valid && !bus_lock, "R2 reset state",
          {28'b0, cmd_ready, done, bus_valid, bus_lock}, 32'h8);
  endtask

  task automatic t_plain_read();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    run_cmd(1'b0, 32'h0000_0002, 16'h0003, 32'h0, e, v, n, k);
    check(v == init_word(19) && !e, "R3 plain read data", v, init_word(19));
    check(n == 2 && k[5:2] == {K_PTR, K_RD}, "R3 plain read beats", 32'(n), 32'd2);
    check(ptr_q == 32'h0002_0003, "R1 pointer word", ptr_q, 32'h0002_0003);
  endtask

  task automatic t_plain_write();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    run_cmd(1'b1, 32'h0000_0001, 16'h0005, 32'hDEAD_BEEF, e, v, n, k);
    check(!e && v == 32'h0 && n == 2 && k[5:2] == {K_PTR, K_WR}, "R4 plain write beats",
          32'(n), 32'd2);
    check(mem[13] == 32'hDEAD_BEEF, "R4 plain write data", mem[13], 32'hDEAD_BEEF);
  endtask

  task automatic t_field_read();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    logic [31:0] exp;
    exp = (init_word(19) >> 4) & 32'hFF;
    run_cmd(1'b0, 32'h0804_0002, 16'h0003, 32'h0, e, v, n, k);
    check(!e && v == exp, "R5 field read", v, exp);
  endtask

  task automatic t_field_write();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    logic [31:0] exp;
    exp = (32'hDEAD_BEEF & ~(32'h1F << 27)) | (32'h15 << 27);
    run_cmd(1'b1, 32'h051B_0001, 16'h0005, 32'h15, e, v, n, k);
    check(!e && n == 3 && k == {K_PTR, K_RD, K_WR}, "R6 field write beats", 32'(n), 32'd3);
    check(mem[13] == exp, "R6 field merge", mem[13], exp);
  endtask

  task automatic t_field_too_wide();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    run_cmd(1'b1, 32'h0400_0001, 16'h0005, 32'h10, e, v, n, k);
    check(e && v == 32'h0, "R7 wide data rejected", {31'b0, e}, 32'h1);
    check(n == 0, "R10 no beats on reject", 32'(n), 32'd0);
  endtask

  task automatic t_bad_args();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    logic [31:0] keep;
    keep = mem[13];
    run_cmd(1'b1, 32'h0000_0001, 16'h0045, 32'h1, e, v, n, k);
    check(e && n == 0 && v == 32'h0, "R8 channel outside mask", {31'b0, e}, 32'h1);
    run_cmd(1'b0, 32'h0000_0801, 16'h0005, 32'h0, e, v, n, k);
    check(e && n == 0, "R8 address outside mask", {31'b0, e}, 32'h1);
    run_cmd(1'b0, 32'h1E04_0001, 16'h0005, 32'h0, e, v, n, k);
    check(e && n == 0, "R9 field past word end", {31'b0, e}, 32'h1);
    run_cmd(1'b1, 32'h0040_0001, 16'h0005, 32'h0, e, v, n, k);
    check(e && n == 0 && v == 32'h0, "R9 reserved bits on plain", {31'b0, e}, 32'h1);
    check(mem[13] == keep, "R10 rejected writes leave word", mem[13], keep);
  endtask

  task automatic t_whole_word();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    run_cmd(1'b1, 32'h2000_0000, 16'h0002, 32'h1234_5678, e, v, n, k);
    check(!e && n == 2 && k[5:2] == {K_PTR, K_WR}, "R11 whole-word write beats", 32'(n), 32'd2);
    run_cmd(1'b0, 32'h2000_0000, 16'h0002, 32'h0, e, v, n, k);
    check(!e && v == 32'h1234_5678, "R11 whole-word read", v, 32'h1234_5678);
  endtask

  task automatic t_stalled_rmw();
    bit e; logic [31:0] v; int n; logic [5:0] k;
    logic [31:0] exp;
    stall_mode = 1'b1;
    exp = (init_word(9) & ~(32'h3FF << 12)) | (32'h2A5 << 12);
    run_cmd(1'b1, 32'h0A0C_0001, 16'h0001, 32'h2A5, e, v, n, k);
    check(!e && n == 3 && mem[9] == exp, "R12 stalled merge", mem[9], exp);
    run_cmd(1'b0, 32'h0A0C_0001, 16'h0001, 32'h0, e, v, n, k);
    check(v == 32'h2A5, "R12 stalled field read", v, 32'h2A5);
    stall_mode = 1'b0;
    check(lock_bad == 0, "R12 lock on every beat", 32'(lock_bad), 32'd0);
  endtask

  // Second command waits on the first one's completion cycle.
  task automatic t_back_to_back();
    int t;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_reg = 32'h0; cmd_chan = 16'h0006;
    cmd_wdata = 32'h0BAD_F00D;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_write = 1'b0; cmd_reg = 32'h1008_0000; cmd_wdata = 32'h0;
    t = 0;
    while (!done && t < 60) begin @(negedge clk); t++; end
    check(done && !cmd_ready, "R2 no accept on done", {31'b0, cmd_ready}, 32'h0);
    @(negedge clk);
    check(cmd_ready, "R2 ready after done", {31'b0, cmd_ready}, 32'h1);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 60) begin @(negedge clk); t++; end
    check(done && !rsp_err && rsp_rdata == 32'hADF0, "R5 read after queued write",
          rsp_rdata, 32'hADF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_read();
    t_plain_write();
    t_field_read();
    t_field_write();
    t_field_too_wide();
    t_bad_args();
    t_whole_word();
    t_stalled_rmw();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule